// File: doc/BRIEF.md
# Serial Control Word Loader

This block takes 16-bit command words from a three-wire serial link (bit clock, data, active-low frame select) and turns them into parallel register writes for a frequency/phase synthesizer core. Each write command carries one data byte. The byte goes into one half of a 16-bit staging register. A deferred write stops there. A direct write also sends the whole staging register out as one 16-bit write to the addressed destination. The staging register keeps its contents after a send, so once both halves hold the intended values, a single direct write can change just one byte of a destination.

Two further command types set control flags that go to the core as plain pins. One sets the synchronous-load flag and the selector-source flag. The other sets the power-down and accumulator-hold levels, and it can zero the two flags with a self-clearing clear bit.

The serial pins are resynchronised into the master clock domain and sampled there. Bits are taken MSB first on falling bit-clock edges.

Each destination write leaves on a valid/ready port. The write stays presented, unchanged, until the consumer takes it with ready high. A new commit that arrives while a write is still pending replaces that write. The serial link cannot be stalled, so the consumer must accept a write within one frame time.

Top module: `scwl_loader`

## Requirements
- R1: While reset is held and right after it, wr_valid, wr_addr, wr_data, sync_en, src_sel, sleep and acc_reset are all 0, and the staging register holds zero.
- R2: A command is formed from the first 16 sdata bits sampled on falling sclk edges while fsync_n is low, MSB first. It takes effect only after the 16th falling edge. Further edges in the same frame are ignored.
- R3: If fsync_n rises before the 16th falling edge, the frame is discarded. Flags, staging register and write port are left unchanged.
- R4: Bits [15:14]=00 mark a write command, laid out as follows:
  - bit 13: 1 = direct, 0 = deferred.
  - bit 12: selects the staging half (1 = high byte, 0 = low byte).
  - bits [11:8]: destination. 00ff means frequency register bit 9, half bit 8 (1 = upper). 01pp means phase register pp.
  - bits [7:0]: the data byte.
  
  A deferred write only loads the selected staging half and produces no write.
- R5: A direct write loads the selected staging half and then issues one write. wr_data is the full 16-bit staging value. wr_addr is {bits 10, 9, 8}, so codes 0–3 are frequency halves and 4–7 are phase registers.
- R6: The staging register keeps its value after a commit, so a direct write to one half issues the new byte together with the retained other byte.
- R7: A write to a phase destination carries only its low 12 bits; wr_data bits [15:12] are 0.
- R8: Bits [15:14]=10 load sync_en from bit 13 and src_sel from bit 12.
- R9: Bits [15:14]=11 load sleep from bit 13 and acc_reset from bit 12. If bit 11 is 1, sync_en and src_sel are also zeroed. The clear bit is not stored.
- R10: wr_valid stays high with stable wr_addr/wr_data until wr_ready is sampled high. A newer commit replaces a pending write.
- R11: With sync_en high, a commit reaches wr_valid SYNC_EXTRA master cycles later than with sync_en low.
- R12: Bits [15:14]=01, and write commands with destination bit 11 set, change nothing: no write, no flag change and no staging update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sclk | input | 1 | Serial bit clock, idles high |
| sdata | input | 1 | Serial data, MSB first |
| fsync_n | input | 1 | Frame select, active low |
| wr_valid | output | 1 | Destination write presented |
| wr_ready | input | 1 | Consumer takes the write |
| wr_addr | output | 3 | Destination code (0–3 frequency halves, 4–7 phase) |
| wr_data | output | 16 | Destination word |
| sync_en | output | 1 | Synchronous-load flag |
| src_sel | output | 1 | Selector-source flag |
| sleep | output | 1 | Power-down level |
| acc_reset | output | 1 | Accumulator hold level |

## Verification
The bench builds the block with PHASE_W=12, SYNC_STAGES=2 and SYNC_EXTRA=2, and drives sclk at eight master cycles per bit. Because SYNC_EXTRA is 2, the latency gap between sync-off and sync-on commits can be measured as an exact two-cycle difference at the ports. With a 12-bit phase width, masking of the top nibble is visible in the phase writes. The slow bit clock leaves room to hold a write pending across a whole following frame, which exercises the replacement rule.

// File: rtl/scwl_pkg.sv
package scwl_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned BYTE_W = WORD_W / 2;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [1:0] {
    OP_WRITE = 2'b00,
    OP_RSVD  = 2'b01,
    OP_CTRL  = 2'b10,
    OP_POWER = 2'b11
  } op_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [WORD_W-1:0] data;
  } wr_req_t;
endpackage

// File: rtl/scwl_sync.sv
module scwl_sync #(
  parameter int unsigned WIDTH = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);
  logic [STAGES-1:0][WIDTH-1:0] pipe;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pipe <= {STAGES{RST_VAL}};
    end else begin
      pipe[0] <= d_in;
      for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
    end
  end

  assign d_out = pipe[STAGES-1];
endmodule

// File: rtl/scwl_deser.sv
module scwl_deser
  import scwl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              sdata_s,
  input  logic              fsync_n_s,
  output logic              word_valid,
  output logic [WORD_W-1:0] word
);
  localparam int unsigned CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(WORD_W);

  logic             sclk_d;
  logic [CNT_W-1:0] bit_cnt;
  logic [WORD_W-1:0] shreg;
  logic             fall;

  assign fall = sclk_d & ~sclk_s;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_d     <= 1'b1;
      bit_cnt    <= '0;
      shreg      <= '0;
      word_valid <= 1'b0;
    end else begin
      sclk_d     <= sclk_s;
      word_valid <= 1'b0;
      if (fsync_n_s) begin
        bit_cnt <= '0;
      end else if (fall && (bit_cnt < FULL_CNT)) begin
        shreg   <= {shreg[WORD_W-2:0], sdata_s};
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == LAST_BIT) word_valid <= 1'b1;
      end
    end
  end

  assign word = shreg;

  AST_ONE_WORD_PER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid); // R2
  AST_ABORT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    fsync_n_s |=> !word_valid); // R3
endmodule

// File: rtl/scwl_decode.sv
module scwl_decode
  import scwl_pkg::*;
#(
  parameter int unsigned PHASE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_valid,
  input  logic [WORD_W-1:0] word,
  output logic              commit,
  output wr_req_t           req,
  output logic              sync_en,
  output logic              src_sel,
  output logic              sleep,
  output logic              acc_reset
);
  logic [WORD_W-1:0] phase_mask;

  generate
    if (PHASE_W >= WORD_W) begin : g_full_phase
      assign phase_mask = '1;
    end else begin : g_narrow_phase
      assign phase_mask = {{(WORD_W-PHASE_W){1'b0}}, {PHASE_W{1'b1}}};
    end
  endgenerate

  op_e               op;
  logic              direct;
  logic              hi_half;
  logic [3:0]        dest;
  logic [BYTE_W-1:0] dbyte;
  logic              dest_ok;
  logic              is_phase;
  logic [WORD_W-1:0] defer_q;
  logic [WORD_W-1:0] defer_nxt;

  assign op       = op_e'(word[WORD_W-1 -: 2]);
  assign direct   = word[13];
  assign hi_half  = word[12];
  assign dest     = word[11:8];
  assign dbyte    = word[BYTE_W-1:0];
  assign dest_ok  = (dest[3] == 1'b0);
  assign is_phase = dest[2];
  assign defer_nxt = hi_half ? {dbyte, defer_q[BYTE_W-1:0]}
                             : {defer_q[WORD_W-1:BYTE_W], dbyte};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      defer_q   <= '0;
      commit    <= 1'b0;
      req       <= '0;
      sync_en   <= 1'b0;
      src_sel   <= 1'b0;
      sleep     <= 1'b0;
      acc_reset <= 1'b0;
    end else begin
      commit <= 1'b0;
      if (word_valid) begin
        unique case (op)
          OP_WRITE: begin
            if (dest_ok) begin
              defer_q <= defer_nxt;
              if (direct) begin
                commit    <= 1'b1;
                req.addr  <= dest[2:0];
                req.data  <= is_phase ? (defer_nxt & phase_mask) : defer_nxt;
              end
            end
          end
          OP_CTRL: begin
            sync_en <= word[13];
            src_sel <= word[12];
          end
          OP_POWER: begin
            sleep     <= word[13];
            acc_reset <= word[12];
            if (word[11]) begin
              sync_en <= 1'b0;
              src_sel <= 1'b0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_COMMIT_NEEDS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> $past(word_valid)); // R5
  AST_CLEAR_ZEROES_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && op == OP_POWER && word[11]) |=> (!sync_en && !src_sel)); // R9
  AST_RSVD_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && op == OP_RSVD) |=> (!commit && $stable(sync_en) && $stable(src_sel))); // R12
endmodule

// File: rtl/scwl_wr_port.sv
module scwl_wr_port
  import scwl_pkg::*;
#(
  parameter int unsigned SYNC_EXTRA = 2,
  parameter int unsigned PHASE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  wr_req_t           req_in,
  input  logic              sync_en,
  input  logic              wr_ready,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [WORD_W-1:0] wr_data
);
  localparam int unsigned WAIT_W = (SYNC_EXTRA > 0) ? $clog2(SYNC_EXTRA + 1) : 1;
  localparam logic [WAIT_W-1:0] WAIT_LOAD = WAIT_W'(SYNC_EXTRA);

  wr_req_t           held;
  logic [WAIT_W-1:0] wait_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held     <= '0;
      wait_cnt <= '0;
      wr_valid <= 1'b0;
    end else if (commit) begin
      held <= req_in;
      if (sync_en && (SYNC_EXTRA > 0)) begin
        wait_cnt <= WAIT_LOAD;
        wr_valid <= 1'b0;
      end else begin
        wait_cnt <= '0;
        wr_valid <= 1'b1;
      end
    end else if (wait_cnt != '0) begin
      if (wait_cnt == WAIT_W'(1)) wr_valid <= 1'b1;
      wait_cnt <= wait_cnt - 1'b1;
    end else if (wr_valid && wr_ready) begin
      wr_valid <= 1'b0;
    end
  end

  assign wr_addr = held.addr;
  assign wr_data = held.data;

  AST_HOLD_UNTIL_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready && !commit) |=> (wr_valid && $stable(wr_data) && $stable(wr_addr))); // R10
  AST_PHASE_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_addr[2]) |-> ((wr_data >> PHASE_W) == '0)); // R7
  AST_SYNC_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && sync_en && (SYNC_EXTRA > 0)) |=> !wr_valid); // R11
endmodule

// File: rtl/scwl_loader.sv
module scwl_loader
  import scwl_pkg::*;
#(
  parameter int unsigned PHASE_W = 12,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned SYNC_EXTRA = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sclk,
  input  logic        sdata,
  input  logic        fsync_n,
  output logic        wr_valid,
  input  logic        wr_ready,
  output logic [2:0]  wr_addr,
  output logic [15:0] wr_data,
  output logic        sync_en,
  output logic        src_sel,
  output logic        sleep,
  output logic        acc_reset
);
  logic [2:0]        pins_s;
  logic              word_valid;
  logic [WORD_W-1:0] word;
  logic              commit;
  wr_req_t           req;

  // Order: {sclk, sdata, fsync_n}; idle level of sclk and fsync_n is high.
  scwl_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b101)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in({sclk, sdata, fsync_n}), .d_out(pins_s)
  );

  scwl_deser u_deser (
    .clk(clk), .rst_n(rst_n),
    .sclk_s(pins_s[2]), .sdata_s(pins_s[1]), .fsync_n_s(pins_s[0]),
    .word_valid(word_valid), .word(word)
  );

  scwl_decode #(.PHASE_W(PHASE_W)) u_decode (
    .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word(word),
    .commit(commit), .req(req), .sync_en(sync_en), .src_sel(src_sel),
    .sleep(sleep), .acc_reset(acc_reset)
  );

  scwl_wr_port #(.SYNC_EXTRA(SYNC_EXTRA), .PHASE_W(PHASE_W)) u_port (
    .clk(clk), .rst_n(rst_n), .commit(commit), .req_in(req), .sync_en(sync_en),
    .wr_ready(wr_ready), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data)
  );
endmodule

// File: tb/scwl_loader_test.sv
module scwl_loader_test;
  localparam int unsigned EXTRA = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b1, sdata = 1'b0, fsync_n = 1'b1, wr_ready = 1'b0;
  logic wr_valid, sync_en, src_sel, sleep, acc_reset;
  logic [2:0] wr_addr;
  logic [15:0] wr_data;

  int checks = 0, failures = 0;
  int cyc = 0, last_fall = 0, rise_cyc = 0, lat0 = 0, lat1 = 0;
  bit done = 1'b0;
  logic prev_v = 1'b0;

  scwl_loader #(.PHASE_W(12), .SYNC_STAGES(2), .SYNC_EXTRA(EXTRA)) uut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdata(sdata), .fsync_n(fsync_n),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .sync_en(sync_en), .src_sel(src_sel), .sleep(sleep), .acc_reset(acc_reset)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) begin
    if (wr_valid && !prev_v) rise_cyc = cyc;
    prev_v = wr_valid;
  end

  // {command, expect write, addr, data}
  localparam logic [35:0] VEC [10] = '{
    {16'h0034, 1'b0, 3'd0, 16'h0000},  // R4 deferred low
    {16'h3012, 1'b1, 3'd0, 16'h1234},  // R5 direct high
    {16'h2056, 1'b1, 3'd0, 16'h1256},  // R6 retained high byte
    {16'h13AB, 1'b0, 3'd0, 16'h0000},  // R4 deferred high
    {16'h23CD, 1'b1, 3'd3, 16'hABCD},  // R5 frequency 1 upper
    {16'h36F7, 1'b1, 3'd6, 16'h07CD},  // R7 phase 2 masked
    {16'h4FFF, 1'b0, 3'd0, 16'h0000},  // R12 reserved op
    {16'h2411, 1'b1, 3'd4, 16'h0711},  // R12 staging untouched, R7
    {16'h2899, 1'b0, 3'd0, 16'h0000},  // R12 bad destination
    {16'h3222, 1'b1, 3'd2, 16'h2211}   // R12 low byte untouched
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [15:0] w, input int nbits);
    @(negedge clk) fsync_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      sdata = (i < 16) ? w[15-i] : 1'b1;
      repeat (4) @(negedge clk);
      sclk = 1'b0;
      last_fall = cyc;
      repeat (4) @(negedge clk);
      sclk = 1'b1;
    end
    repeat (4) @(negedge clk);
    fsync_n = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  task automatic take();
    wr_ready = 1'b1;
    @(negedge clk);
    wr_ready = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!wr_valid && wr_addr == 0 && wr_data == 0 && !sync_en && !src_sel && !sleep && !acc_reset,
          "R1", {wr_valid, wr_addr, wr_data}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!wr_valid && !sync_en && !sleep, "R1", {wr_valid, sync_en, sleep}, 0);

    for (int i = 0; i < 10; i++) begin
      send(VEC[i][35:20], 16);
      if (VEC[i][19]) begin
        check(wr_valid == 1'b1, "R5", wr_valid, 1);
        check(wr_addr == VEC[i][18:16] && wr_data == VEC[i][15:0], "R5/R6/R7 vector",
              {wr_addr, wr_data}, {VEC[i][18:16], VEC[i][15:0]});
        if (i == 1) lat0 = rise_cyc - last_fall;
        take();
        check(!wr_valid, "R10 taken", wr_valid, 0);
      end else begin
        check(!wr_valid, "R4/R12 no write", wr_valid, 0);
      end
    end
    check(!sync_en && !src_sel, "R12 flags", {sync_en, src_sel}, 0);

    send(16'hB000, 16);                           // R8
    check(sync_en && src_sel, "R8", {sync_en, src_sel}, 2'b11);
    send(16'h9000, 16);
    check(!sync_en && src_sel, "R8", {sync_en, src_sel}, 2'b01);

    send(16'hA000, 16);                           // R11: sync on
    send(16'h3077, 16);
    lat1 = rise_cyc - last_fall;
    check(wr_valid && wr_addr == 0 && wr_data == 16'h7711, "R11 data", {wr_addr, wr_data}, 16'h7711);
    check(lat1 - lat0 == EXTRA, "R11 latency", lat1 - lat0, EXTRA);
    take();

    send(16'hB000, 16);                           // R9
    send(16'hF000, 16);
    check(sleep && acc_reset && sync_en && src_sel, "R9 power",
          {sleep, acc_reset, sync_en, src_sel}, 4'hF);
    send(16'hC800, 16);
    check(!sleep && !acc_reset && !sync_en && !src_sel, "R9 clear",
          {sleep, acc_reset, sync_en, src_sel}, 0);

    send(16'hB000, 10);                           // R3
    check(!sync_en && !src_sel, "R3 flags", {sync_en, src_sel}, 0);
    send(16'h3099, 12);
    check(!wr_valid, "R3 no write", wr_valid, 0);
    send(16'h2055, 16);
    check(wr_valid && wr_data == 16'h7755, "R3 staging", wr_data, 16'h7755);
    take();

    send(16'hA000, 20);                           // R2 extra edges
    check(sync_en && !src_sel, "R2", {sync_en, src_sel}, 2'b10);
    send(16'hC800, 16);

    send(16'h30AA, 16);                           // R10 hold
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      check(wr_valid && wr_addr == 0 && wr_data == 16'hAA55, "R10 hold", {wr_addr, wr_data}, 16'hAA55);
    end
    send(16'h2166, 16);
    check(wr_valid && wr_addr == 3'd1 && wr_data == 16'hAA66, "R10 replace",
          {wr_addr, wr_data}, {3'd1, 16'hAA66});
    take();
    check(!wr_valid, "R10 released", wr_valid, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule